// File: doc/BRIEF.md
# Delayed Trigger Sequencer

This block turns a main trigger into a second, delayed trigger. Once a main trigger has been taken, the block counts clock ticks, or events that an upstream detector reports on a source strobe, or events and then ticks. When the count runs out, it issues a one-cycle delayed-trigger strobe. Event detection takes place upstream, so this block sees only single-cycle strobes.

The main trigger is taken in one of three ways. In normal mode the block waits for a main strobe for as long as it takes. In auto mode it also triggers itself when no main strobe arrives within a programmed holdoff. In single mode it completes one sequence and then stays halted until software pulses the arm input. A pulse on arm also ends any sequence in progress and returns the block to waiting. The status output busy covers the delay phase, and done shows that a sequence has completed.

Top module: `dly_trig_seq`

## Requirements
- R1: After reset, dly_trig, main_fire, busy and done are low, and the block waits for a main trigger.
- R2: Delay mode code 0 (time; code 3 acts the same) raises dly_trig for exactly one cycle, max(dly_ticks,1) rising edges after the edge that sampled the accepted main strobe.
- R3: Delay mode code 1 (events) raises dly_trig right after the edge that samples the N-th src_evt strobe while busy. A src_evt sampled while waiting, or at the accepting edge, is not counted.
- R4: Delay mode code 2 (events then time) raises dly_trig max(dly_ticks,1) edges after the edge that sampled the N-th counted event.
- R5: The event target N is evt_count limited to the range 2 to 9999999. A value below 2 counts as 2.
- R6: main_fire is high for the one cycle after the edge that accepts a main trigger. busy is high from that cycle until dly_trig rises, and is low in the cycle dly_trig is high.
- R7: A main_trig strobe that arrives while busy is ignored: it produces no main_fire and does not restart the delay.
- R8: Trigger mode code 1 (normal; code 3 acts the same) never triggers without a main_trig strobe, and returns to waiting after each delayed strobe.
- R9: Trigger mode code 0 (auto) with no main strobe accepts a trigger by itself on the max(holdoff_ticks,1)-th edge after waiting starts.
- R10: Trigger mode code 2 (single) halts after its delayed strobe. While halted it ignores main_trig and keeps done high. An arm pulse returns it to waiting.
- R11: done rises together with dly_trig and falls at the next accepted main trigger or at an arm pulse.
- R12: An arm pulse during a sequence ends it: busy falls after that edge and no dly_trig follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Re-arm and abort pulse |
| trig_mode | input | 2 | 0 auto, 1 normal, 2 single, 3 normal |
| dly_mode | input | 2 | 0 time, 1 events, 2 events then time, 3 time |
| evt_count | input | EVT_W (24) | Event target, clamped to 2..9999999 |
| dly_ticks | input | TIME_W (20) | Time delay in clock ticks, 0 read as 1 |
| holdoff_ticks | input | HOLD_W (16) | Auto-mode holdoff in ticks, 0 read as 1 |
| main_trig | input | 1 | Main trigger strobe |
| src_evt | input | 1 | Delayed-source event strobe |
| main_fire | output | 1 | Pulse: a main trigger was accepted |
| dly_trig | output | 1 | Pulse: delayed trigger |
| busy | output | 1 | Delay phase in progress |
| done | output | 1 | A sequence has completed |

## Verification
The assertions assume that holdoff_ticks does not change while the block is waiting in auto mode. A lower value written in the middle of a wait would leave the holdoff count above its new end point. They also assume that main_trig and src_evt are synchronous single-bit strobes. The stimulus writes every setting one cycle ahead of the main strobe that uses it, and it changes the trigger mode only before an arm pulse. Random gaps between events, extra main strobes during the delay, and src_evt pulses before arming probe the counting rules within those limits.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [1:0] {
    DM_TIME     = 2'd0,
    DM_EVENTS   = 2'd1,
    DM_EVT_TIME = 2'd2,
    DM_RSVD     = 2'd3
  } dly_mode_e;

  typedef enum logic [1:0] {
    TM_AUTO   = 2'd0,
    TM_NORMAL = 2'd1,
    TM_SINGLE = 2'd2,
    TM_RSVD   = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    PH_WAIT,
    PH_EVT,
    PH_TIME,
    PH_HALT
  } phase_e;

  localparam logic [31:0] EVT_FLOOR = 32'd2;
  localparam logic [31:0] EVT_CEIL  = 32'd9999999;

  // legal event target
  function automatic logic [31:0] clamp_evt(input logic [31:0] n);
    if (n < EVT_FLOOR) return EVT_FLOOR;
    if (n > EVT_CEIL)  return EVT_CEIL;
    return n;
  endfunction

  // a zero tick count is read as one tick
  function automatic logic [31:0] at_least_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/dts_down_cnt.sv
module dts_down_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (step && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = step && (cnt == W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt != '0)); // R2

endmodule

// File: rtl/dts_holdoff.sv
module dts_holdoff #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] hcnt;
  logic [W-1:0] lim_m1;

  assign lim_m1 = (limit == '0) ? '0 : limit - 1'b1;
  assign expire = en && (hcnt == lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)   hcnt <= '0;
    else if (clr) hcnt <= '0;
    else if (en)  hcnt <= expire ? '0 : hcnt + 1'b1;
  end

  AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (hcnt <= lim_m1)); // R9

endmodule

// File: rtl/dly_trig_seq.sv
module dly_trig_seq
  import dts_pkg::*;
#(
  parameter int EVT_W  = 24,
  parameter int TIME_W = 20,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [1:0]        trig_mode,
  input  logic [1:0]        dly_mode,
  input  logic [EVT_W-1:0]  evt_count,
  input  logic [TIME_W-1:0] dly_ticks,
  input  logic [HOLD_W-1:0] holdoff_ticks,
  input  logic              main_trig,
  input  logic              src_evt,
  output logic              main_fire,
  output logic              dly_trig,
  output logic              busy,
  output logic              done
);

  localparam logic [EVT_W-1:0] EVT_CEIL_W = EVT_W'(EVT_CEIL);

  phase_e            ph;
  dly_mode_e         mode_q;
  trig_mode_e        tm_q;
  logic [TIME_W-1:0] dly_q;

  // named internal events
  logic              waiting;
  logic              auto_exp;
  logic              accept;
  logic              use_evt_in;
  logic              evt_load, evt_step, evt_last;
  logic              chain;
  logic              tick_load, tick_step, tick_last;
  logic              fire_now;
  logic [EVT_W-1:0]  evt_target;
  logic [TIME_W-1:0] ticks_in;
  logic [TIME_W-1:0] tick_val;
  phase_e            after_fire;

  assign waiting    = (ph == PH_WAIT);
  assign use_evt_in = (dly_mode == DM_EVENTS) || (dly_mode == DM_EVT_TIME);
  assign accept     = waiting && !arm && (main_trig || auto_exp);
  assign evt_target = EVT_W'(clamp_evt(32'(evt_count)));
  assign ticks_in   = TIME_W'(at_least_one(32'(dly_ticks)));

  dts_holdoff #(.W(HOLD_W)) i_holdoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!waiting || arm),
    .en     (waiting && (trig_mode == TM_AUTO)),
    .limit  (holdoff_ticks),
    .expire (auto_exp)
  );

  assign evt_load = accept && use_evt_in;
  assign evt_step = (ph == PH_EVT) && src_evt;

  dts_down_cnt #(.W(EVT_W)) i_evt_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt_load),
    .load_val (evt_target),
    .step     (evt_step),
    .last     (evt_last)
  );

  assign chain     = (ph == PH_EVT) && evt_last && (mode_q == DM_EVT_TIME);
  assign tick_load = (accept && !use_evt_in) || chain;
  assign tick_val  = accept ? ticks_in : dly_q;
  assign tick_step = (ph == PH_TIME);

  dts_down_cnt #(.W(TIME_W)) i_tick_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tick_load),
    .load_val (tick_val),
    .step     (tick_step),
    .last     (tick_last)
  );

  assign fire_now   = !arm && (((ph == PH_EVT) && evt_last && (mode_q == DM_EVENTS)) ||
                               ((ph == PH_TIME) && tick_last));
  assign after_fire = (tm_q == TM_SINGLE) ? PH_HALT : PH_WAIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_WAIT;
      mode_q    <= DM_TIME;
      tm_q      <= TM_NORMAL;
      dly_q     <= '0;
      main_fire <= 1'b0;
      dly_trig  <= 1'b0;
      done      <= 1'b0;
    end else begin
      main_fire <= accept;
      dly_trig  <= fire_now;
      if (arm) begin
        ph   <= PH_WAIT;
        done <= 1'b0;
      end else if (accept) begin
        ph     <= use_evt_in ? PH_EVT : PH_TIME;
        mode_q <= !use_evt_in ? DM_TIME :
                  (dly_mode == DM_EVT_TIME) ? DM_EVT_TIME : DM_EVENTS;
        tm_q   <= trig_mode_e'(trig_mode);
        dly_q  <= ticks_in;
        done   <= 1'b0;
      end else if (chain) begin
        ph <= PH_TIME;
      end else if (fire_now) begin
        ph   <= after_fire;
        done <= 1'b1;
      end
    end
  end

  assign busy = (ph == PH_EVT) || (ph == PH_TIME);

  AST_EVT_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load |-> (evt_target >= EVT_W'(2)) && (evt_target <= EVT_CEIL_W)); // R5
  AST_BUSY_BLOCKS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && main_trig && !arm) |=> !main_fire); // R7
  AST_DLY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dly_trig |-> (!busy && $past(busy))); // R6
  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_trig |=> !dly_trig); // R2
  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_HALT) && !arm) |=> (ph == PH_HALT) && !main_fire); // R10
  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> dly_trig); // R11
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!busy && !done && !dly_trig)); // R12

endmodule

// File: tb/test_dly_trig_seq.sv
module test_dly_trig_seq;

  localparam int EVT_W  = 24;
  localparam int TIME_W = 20;
  localparam int HOLD_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              arm;
  logic [1:0]        trig_mode;
  logic [1:0]        dly_mode;
  logic [EVT_W-1:0]  evt_count;
  logic [TIME_W-1:0] dly_ticks;
  logic [HOLD_W-1:0] holdoff_ticks;
  logic              main_trig;
  logic              src_evt;
  logic              main_fire, dly_trig, busy, done;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dly_trig_seq #(.EVT_W(EVT_W), .TIME_W(TIME_W), .HOLD_W(HOLD_W)) i_dly_trig_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_mode(trig_mode), .dly_mode(dly_mode),
    .evt_count(evt_count), .dly_ticks(dly_ticks), .holdoff_ticks(holdoff_ticks),
    .main_trig(main_trig), .src_evt(src_evt), .main_fire(main_fire),
    .dly_trig(dly_trig), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_target(input int n);
    if (n < 2) return 2;
    if (n > 9999999) return 9999999;
    return n;
  endfunction

  function automatic int ref_ticks(input int d);
    return (d < 1) ? 1 : d;
  endfunction

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // One full sequence from the waiting state. Edge count e is relative to the accepting edge.
  task automatic run_seq(input int dm, input int n, input int d);
    string req;
    int    evt_left;
    int    exp_edge;
    int    fire_e;
    int    e;
    bit    busy_ok;
    bit    quiet_ok;
    req = (dm == 1) ? "R3" : (dm == 2) ? "R4" : "R2";
    // R3: events while waiting are not counted
    @(negedge clk); src_evt = 1'b1;
    @(negedge clk); src_evt = 1'b0;
    @(negedge clk);
    dly_mode = 2'(dm); evt_count = EVT_W'(n); dly_ticks = TIME_W'(d);
    @(negedge clk); main_trig = 1'b1; src_evt = 1'b1;  // src_evt at the accepting edge is ignored
    @(negedge clk); main_trig = 1'b0; src_evt = 1'b0;
    chk(main_fire == 1'b1, "R6 main_fire", int'(main_fire), 1);
    chk(busy == 1'b1, "R6 busy", int'(busy), 1);
    chk(done == 1'b0, "R11 done cleared by accept", int'(done), 0);
    evt_left = (dm == 1 || dm == 2) ? ref_target(n) : 0;
    exp_edge = (dm == 1 || dm == 2) ? -1 : ref_ticks(d);
    fire_e = -1; e = 0; busy_ok = 1'b1; quiet_ok = 1'b1;
    while (e < 600 && fire_e < 0) begin
      if (evt_left > 0 && ($urandom % 3 == 0)) begin
        src_evt = 1'b1;
        evt_left--;
        if (evt_left == 0) exp_edge = (dm == 1) ? e + 1 : e + 1 + ref_ticks(d);
      end else begin
        src_evt = 1'b0;
      end
      main_trig = ($urandom % 4 == 0);  // R7: strobes during the delay
      @(negedge clk); e++;
      if (main_fire) quiet_ok = 1'b0;
      if (dly_trig) fire_e = e;
      else if (!busy) busy_ok = 1'b0;
    end
    main_trig = 1'b0; src_evt = 1'b0;
    chk(fire_e == exp_edge, req, fire_e, exp_edge);
    chk(busy_ok, "R6 busy held", int'(busy_ok), 1);
    chk(quiet_ok, "R7 main ignored while busy", int'(quiet_ok), 1);
    chk(busy == 1'b0, "R6 busy low at fire", int'(busy), 0);
    chk(done == 1'b1, "R11 done at fire", int'(done), 1);
    @(negedge clk);
    chk(dly_trig == 1'b0, "R2 single-cycle strobe", int'(dly_trig), 0);
    chk(main_fire == 1'b0, "R7 no late accept", int'(main_fire), 0);
  endtask

  // Auto mode: edges after an arm pulse at which main_fire and dly_trig are seen.
  task automatic run_auto(input int h, input int d);
    int e;
    int mf[2];
    int df[2];
    int nm;
    int nd;
    int hh;
    hh = ref_ticks(h);
    nm = 0; nd = 0;
    @(negedge clk);
    trig_mode = 2'd0; dly_mode = 2'd0; dly_ticks = TIME_W'(d); holdoff_ticks = HOLD_W'(h);
    arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    for (e = 1; e <= 2 * (hh + ref_ticks(d)) + 2; e++) begin
      @(negedge clk);
      if (main_fire && nm < 2) begin mf[nm] = e; nm++; end
      if (dly_trig && nd < 2) begin df[nd] = e; nd++; end
    end
    chk(nm == 2, "R9 auto count", nm, 2);
    chk(nd == 2, "R9 auto delayed count", nd, 2);
    if (nm == 2 && nd == 2) begin
      chk(mf[0] == hh, "R9 first auto trigger", mf[0], hh);
      chk(df[0] == hh + ref_ticks(d), "R9 first delayed", df[0], hh + ref_ticks(d));
      chk(mf[1] == df[0] + hh, "R9 holdoff restarts", mf[1], df[0] + hh);
      chk(df[1] == mf[1] + ref_ticks(d), "R9 second delayed", df[1], mf[1] + ref_ticks(d));
    end
    @(negedge clk); trig_mode = 2'd1;
    pulse_arm();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; arm = 1'b0; trig_mode = 2'd1; dly_mode = 2'd0;
    evt_count = '0; dly_ticks = '0; holdoff_ticks = '0; main_trig = 1'b0; src_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dly_trig == 1'b0, "R1 dly_trig", int'(dly_trig), 0);
    chk(main_fire == 1'b0, "R1 main_fire", int'(main_fire), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);

    // R8: normal mode never fires by itself
    begin
      bit idle_ok;
      idle_ok = 1'b1;
      repeat (60) begin
        @(negedge clk);
        if (main_fire || busy || dly_trig) idle_ok = 1'b0;
      end
      chk(idle_ok, "R8 normal waits", int'(idle_ok), 1);
    end

    // directed corners
    run_seq(0, 0, 0);   // R2: zero ticks read as one
    run_seq(0, 0, 1);
    run_seq(3, 0, 5);   // R2: code 3 acts as time
    run_seq(1, 0, 0);   // R5: target 0 counts as 2
    run_seq(1, 1, 0);   // R5: target 1 counts as 2
    run_seq(1, 2, 0);   // R3
    run_seq(2, 2, 0);   // R4: zero ticks after the events
    run_seq(2, 3, 7);   // R4
    run_seq(1, 9, 0);   // R8: normal mode re-arms after each strobe

    // constrained random sequences
    for (int i = 0; i < 24; i++) begin
      run_seq(int'($urandom % 4), int'($urandom % 12), int'($urandom % 16));
    end

    // R9: auto mode
    run_auto(5, 3);
    run_auto(0, 2);

    // R10: single mode
    @(negedge clk); trig_mode = 2'd2;
    run_seq(0, 0, 2);
    begin
      bit halt_ok;
      halt_ok = 1'b1;
      repeat (10) begin
        main_trig = 1'b1;
        @(negedge clk);
        if (main_fire || busy || !done) halt_ok = 1'b0;
      end
      main_trig = 1'b0;
      @(negedge clk);
      if (main_fire || busy || !done) halt_ok = 1'b0;
      chk(halt_ok, "R10 halted after single", int'(halt_ok), 1);
    end
    pulse_arm();
    chk(done == 1'b0, "R11 done cleared by arm", int'(done), 0);
    run_seq(1, 4, 0);   // R10: accepted again after arm
    @(negedge clk); trig_mode = 2'd1;
    pulse_arm();

    // R12: arm aborts a running delay
    @(negedge clk); dly_mode = 2'd0; dly_ticks = TIME_W'(20);
    @(negedge clk); main_trig = 1'b1;
    @(negedge clk); main_trig = 1'b0;
    chk(busy == 1'b1, "R12 started", int'(busy), 1);
    repeat (4) @(negedge clk);
    arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    chk(busy == 1'b0, "R12 busy dropped", int'(busy), 0);
    begin
      bit abort_ok;
      abort_ok = 1'b1;
      repeat (30) begin
        @(negedge clk);
        if (dly_trig || busy || done) abort_ok = 1'b0;
      end
      chk(abort_ok, "R12 no strobe after abort", int'(abort_ok), 1);
    end
    run_seq(0, 0, 3);   // R12: waiting again after abort

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule